// File: doc/BRIEF.md
# Cluster Thread-Block Dispatcher

This block hands thread blocks of launched kernels to the cores of one cluster. Each core has a small queue of pending blocks, each entry holding a kernel number. Every cycle has two phases. In the fill phase, each core with room in its queue receives at most one block from the kernel chosen for it, and that kernel's allocated-block counter goes up by one. In the issue phase, a round-robin scan picks at most one core and dispatches the block at the head of its queue.

Kernel choice depends on a mode pin. In concurrent mode every fill uses the kernel that the global selector currently reports. In the other mode, each core keeps its own current kernel. The core takes the selector's kernel only after its kernel has no blocks left, its threads have all completed, and its queue is empty.

Back-pressure works per core. The `core_ready` bit of a core is the ready half of a valid/ready pair for that core: a block leaves a queue only in a cycle where the core's ready bit is high. The dispatch record that follows is a one-cycle pulse and cannot be stalled.

Top module: `cta_dispatch`

## Requirements
- R1: Each core queue holds at most 4 blocks (QDEPTH). A core whose queue already holds 4 is skipped by the fill phase, so allocation stops once all queues are full.
- R2: In concurrent mode (`concurrent_mode`=1), every fill takes the kernel on `sel_kernel` while `sel_valid` is high. Kernels not presented there are never allocated.
- R3: In the other mode, a core keeps its current kernel. It takes the selector's kernel only when three conditions hold: its current kernel is absent or has no blocks left, its `core_busy` bit is 0, and its queue is empty. `core_kernel`/`core_kernel_valid` report each core's current kernel one cycle after a change.
- R4: A block is allocated from kernel k only while `kern_alloc[k]` is below `kern_total[k]`. Each allocation adds one to `kern_alloc[k]`.
- R5: The issue scan starts at the core after the last core that dispatched and wraps modulo the core count.
- R6: A core is eligible when its queue is non-empty and its `core_ready` bit is 1. A block filled in the same cycle counts, so it can dispatch at once. The first eligible core in scan order dispatches, its head is popped, and it becomes the last core that dispatched.
- R7: At most one block is dispatched per cycle. `disp_valid`, `disp_core` and `disp_kernel` appear one clock after the issue decision.
- R8: The fill phase gives at most one block per core per cycle. Cores are taken in ascending index order, so when a kernel runs short the lower-numbered cores are served first.
- R9: With no valid kernel (selector invalid, no current kernel), nothing is allocated and nothing is dispatched.
- R10: After reset, all queues are empty, every allocated counter is 0, no core has a kernel, `disp_valid` is 0, and the scan pointer is at the last core, so the first scan starts at core 0.
- R11: A pulse on `kern_clear[k]` sets `kern_alloc[k]` to 0 at the next edge, taking priority over any fill in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| concurrent_mode | input | 1 | 1: fill from the selector's kernel; 0: per-core kernel ownership |
| sel_valid | input | 1 | Selector reports a kernel |
| sel_kernel | input | KW | Latest selected kernel number |
| kern_total | input | NUM_KERNELS x CW | Total block count of each kernel |
| kern_clear | input | NUM_KERNELS | Zero the allocated counter of a kernel |
| kern_alloc | output | NUM_KERNELS x CW | Allocated block count of each kernel |
| core_busy | input | NUM_CORES | Core still has uncompleted threads |
| core_ready | input | NUM_CORES | Core can accept the block at its queue head |
| core_kernel | output | NUM_CORES x KW | Current kernel of each core |
| core_kernel_valid | output | NUM_CORES | Core has a current kernel |
| disp_valid | output | 1 | A block was dispatched |
| disp_core | output | CIW | Core that received the block |
| disp_kernel | output | KW | Kernel of the dispatched block |

## Verification
The issue phase is exercised with a table of ready masks applied to full queues. Some masks enable every core, some a single core behind the pointer, some none, and some a pair that straddles the wrap point. Together they separate a correct rotating pointer from a fixed-priority scan or one that restarts at core 0. The fill phase is tried with four patterns: a plentiful kernel (the four-deep limit), a kernel of six blocks (index-order sharing and the total limit), a kernel of one block with ready cores (same-cycle dispatch), and an invalid selector. Ownership mode is tried with a busy core and a core whose queue is still non-empty, so that each condition for switching kernels is shown to matter separately.

// File: rtl/cta_disp_pkg.sv
package cta_disp_pkg;
  localparam int DEF_CORES   = 4;
  localparam int DEF_KERNELS = 4;
  localparam int DEF_QDEPTH  = 4;
  localparam int DEF_CW      = 8;
endpackage

// File: rtl/cta_queue.sv
module cta_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic          thru, do_wr, do_rd;

  // a block pushed into an empty queue and popped in the same cycle passes straight through
  assign thru  = push && pop && (cnt == '0);
  assign do_wr = push && !thru;
  assign do_rd = pop && !thru;
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) begin
        mem[wptr] <= din;
        wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (do_rd) rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + NW'(do_wr) - NW'(do_rd);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < NW'(DEPTH)));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0 || push));
endmodule

// File: rtl/cta_fill.sv
module cta_fill #(
  parameter int NUM_CORES   = 4,
  parameter int NUM_KERNELS = 4,
  parameter int DEPTH       = 4,
  parameter int CW          = 8,
  parameter int KW          = 2,
  parameter int NW          = 3
) (
  input  logic                                concurrent_mode,
  input  logic                                sel_valid,
  input  logic [KW-1:0]                       sel_kernel,
  input  logic [NUM_KERNELS-1:0][CW-1:0]      kern_total,
  input  logic [NUM_KERNELS-1:0][CW-1:0]      alloc_q,
  input  logic [NUM_CORES-1:0][NW-1:0]        q_cnt,
  input  logic [NUM_CORES-1:0]                core_busy,
  input  logic [NUM_CORES-1:0][KW-1:0]        cur_k,
  input  logic [NUM_CORES-1:0]                cur_v,
  output logic [NUM_CORES-1:0]                push,
  output logic [NUM_CORES-1:0][KW-1:0]        push_k,
  output logic [NUM_CORES-1:0]                switch_k,
  output logic [NUM_KERNELS-1:0][CW-1:0]      alloc_d
);
  logic [NUM_KERNELS-1:0][CW-1:0] run;
  logic [KW-1:0] use_k;
  logic          use_v;

  // cores visited in index order; later cores see counters already bumped by earlier ones
  always_comb begin
    run      = alloc_q;
    push     = '0;
    push_k   = '0;
    switch_k = '0;
    use_k    = '0;
    use_v    = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      use_k = '0;
      use_v = 1'b0;
      if (q_cnt[c] < NW'(DEPTH)) begin
        if (concurrent_mode) begin
          use_v = sel_valid;
          use_k = sel_kernel;
        end else begin
          use_v = cur_v[c];
          use_k = cur_k[c];
          if (!(cur_v[c] && run[cur_k[c]] < kern_total[cur_k[c]]) &&
              !core_busy[c] && q_cnt[c] == '0) begin
            use_v       = sel_valid;
            use_k       = sel_kernel;
            switch_k[c] = sel_valid;
          end
        end
        if (use_v && run[use_k] < kern_total[use_k]) begin
          push[c]    = 1'b1;
          push_k[c]  = use_k;
          run[use_k] = run[use_k] + 1'b1;
        end
      end
    end
    alloc_d = run;
  end
endmodule

// File: rtl/cta_issue.sv
module cta_issue #(
  parameter int NUM_CORES = 4,
  parameter int CIW       = 2
) (
  input  logic [NUM_CORES-1:0] avail,
  input  logic [NUM_CORES-1:0] ready,
  input  logic [CIW-1:0]       last,
  output logic                 grant,
  output logic [CIW-1:0]       gcore
);
  int idx;

  always_comb begin
    grant = 1'b0;
    gcore = '0;
    idx   = 0;
    for (int i = 1; i <= NUM_CORES; i++) begin
      idx = (int'(last) + i) % NUM_CORES;
      if (!grant && avail[idx] && ready[idx]) begin
        grant = 1'b1;
        gcore = CIW'(idx);
      end
    end
  end
endmodule

// File: rtl/cta_dispatch.sv
module cta_dispatch
  import cta_disp_pkg::*;
#(
  parameter int NUM_CORES   = DEF_CORES,
  parameter int NUM_KERNELS = DEF_KERNELS,
  parameter int QDEPTH      = DEF_QDEPTH,
  parameter int CW          = DEF_CW,
  localparam int KW  = $clog2(NUM_KERNELS),
  localparam int CIW = $clog2(NUM_CORES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           concurrent_mode,
  input  logic                           sel_valid,
  input  logic [KW-1:0]                  sel_kernel,
  input  logic [NUM_KERNELS-1:0][CW-1:0] kern_total,
  input  logic [NUM_KERNELS-1:0]         kern_clear,
  output logic [NUM_KERNELS-1:0][CW-1:0] kern_alloc,
  input  logic [NUM_CORES-1:0]           core_busy,
  input  logic [NUM_CORES-1:0]           core_ready,
  output logic [NUM_CORES-1:0][KW-1:0]   core_kernel,
  output logic [NUM_CORES-1:0]           core_kernel_valid,
  output logic                           disp_valid,
  output logic [CIW-1:0]                 disp_core,
  output logic [KW-1:0]                  disp_kernel
);
  localparam int NW = $clog2(QDEPTH+1);

  logic [NUM_CORES-1:0][NW-1:0]   q_cnt;
  logic [NUM_CORES-1:0][KW-1:0]   q_head, push_k, head_eff;
  logic [NUM_CORES-1:0]           push, pop, avail, switch_k;
  logic [NUM_KERNELS-1:0][CW-1:0] alloc_d;
  logic [CIW-1:0]                 last_ptr, gcore;
  logic                           grant;

  cta_fill #(.NUM_CORES(NUM_CORES), .NUM_KERNELS(NUM_KERNELS), .DEPTH(QDEPTH),
             .CW(CW), .KW(KW), .NW(NW)) u_fill (
    .concurrent_mode(concurrent_mode), .sel_valid(sel_valid), .sel_kernel(sel_kernel),
    .kern_total(kern_total), .alloc_q(kern_alloc), .q_cnt(q_cnt), .core_busy(core_busy),
    .cur_k(core_kernel), .cur_v(core_kernel_valid), .push(push), .push_k(push_k),
    .switch_k(switch_k), .alloc_d(alloc_d));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cta_queue #(.DEPTH(QDEPTH), .DW(KW)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push[c]), .din(push_k[c]), .pop(pop[c]),
      .head(q_head[c]), .cnt(q_cnt[c]));
    assign avail[c]    = (q_cnt[c] != '0) || push[c];
    assign head_eff[c] = (q_cnt[c] != '0) ? q_head[c] : push_k[c];
    assign pop[c]      = grant && (gcore == CIW'(c));
  end

  cta_issue #(.NUM_CORES(NUM_CORES), .CIW(CIW)) u_issue (
    .avail(avail), .ready(core_ready), .last(last_ptr), .grant(grant), .gcore(gcore));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_ptr          <= CIW'(NUM_CORES-1);
      kern_alloc        <= '0;
      core_kernel       <= '0;
      core_kernel_valid <= '0;
      disp_valid        <= 1'b0;
      disp_core         <= '0;
      disp_kernel       <= '0;
    end else begin
      for (int k = 0; k < NUM_KERNELS; k++)
        kern_alloc[k] <= kern_clear[k] ? '0 : alloc_d[k];
      for (int c = 0; c < NUM_CORES; c++)
        if (switch_k[c]) begin
          core_kernel[c]       <= sel_kernel;
          core_kernel_valid[c] <= 1'b1;
        end
      disp_valid <= grant;
      if (grant) begin
        last_ptr    <= gcore;
        disp_core   <= gcore;
        disp_kernel <= head_eff[gcore];
      end
    end
  end

  // R7
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
  // R6
  disp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((($past(core_ready) >> disp_core) & NUM_CORES'(1)) != '0));

  for (genvar k = 0; k < NUM_KERNELS; k++) begin : g_kchk
    // R4
    alloc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(kern_clear[k]) |-> (kern_alloc[k] >= $past(kern_alloc[k])));
  end
endmodule

// File: tb/tb_cta_dispatch.sv
`timescale 1ns/1ps
module tb_cta_dispatch;
  localparam int NC = 4;
  localparam int NK = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic concurrent_mode = 1'b1;
  logic sel_valid = 1'b0;
  logic [1:0] sel_kernel = '0;
  logic [NK-1:0][CW-1:0] kern_total = '0;
  logic [NK-1:0] kern_clear = '0;
  logic [NK-1:0][CW-1:0] kern_alloc;
  logic [NC-1:0] core_busy = '0;
  logic [NC-1:0] core_ready = '0;
  logic [NC-1:0][1:0] core_kernel;
  logic [NC-1:0] core_kernel_valid;
  logic disp_valid;
  logic [1:0] disp_core, disp_kernel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cta_dispatch dut (
    .clk(clk), .rst_n(rst_n), .concurrent_mode(concurrent_mode),
    .sel_valid(sel_valid), .sel_kernel(sel_kernel), .kern_total(kern_total),
    .kern_clear(kern_clear), .kern_alloc(kern_alloc), .core_busy(core_busy),
    .core_ready(core_ready), .core_kernel(core_kernel),
    .core_kernel_valid(core_kernel_valid), .disp_valid(disp_valid),
    .disp_core(disp_core), .disp_kernel(disp_kernel));

  // {ready mask[6:3], expected disp_valid[2], expected disp_core[1:0]}, pointer starts at core 3
  localparam logic [6:0] RR_VEC [8] = '{
    {4'b1111, 1'b1, 2'd0},
    {4'b1111, 1'b1, 2'd1},
    {4'b0001, 1'b1, 2'd0},
    {4'b0000, 1'b0, 2'd0},
    {4'b1001, 1'b1, 2'd3},
    {4'b1001, 1'b1, 2'd0},
    {4'b0100, 1'b1, 2'd2},
    {4'b0110, 1'b1, 2'd1}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic disp_expect(string req, int v, int core, int kern);
    chk(req, disp_valid, v);
    if (v != 0) begin
      chk(req, disp_core, core);
      chk(req, disp_kernel, kern);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    chk("R10 disp_valid", disp_valid, 0);
    chk("R10 core_kernel_valid", core_kernel_valid, 0);
    chk("R10 alloc0", kern_alloc[0], 0);

    // R9 no kernel: nothing allocated or dispatched
    concurrent_mode = 1'b1; sel_valid = 1'b0; kern_total[0] = 8'd50; core_ready = 4'hF;
    tick(); tick(); tick();
    chk("R9 alloc0", kern_alloc[0], 0);
    chk("R9 disp_valid", disp_valid, 0);

    // R1 queues fill to four each, then stop
    core_ready = '0; sel_valid = 1'b1; sel_kernel = 2'd0; kern_total[0] = 8'd200;
    do_reset();
    tick();
    chk("R8 one per core per cycle", kern_alloc[0], 4);
    tick(); tick(); tick();
    chk("R1 full alloc", kern_alloc[0], 16);
    tick();
    chk("R1 no fill when full", kern_alloc[0], 16);

    // R5 R6 round-robin table
    foreach (RR_VEC[i]) begin
      core_ready = RR_VEC[i][6:3];
      tick();
      disp_expect("R5 R6 rr table", RR_VEC[i][2], RR_VEC[i][1:0], 0);
    end

    // R11 counter clear
    core_ready = '0;
    repeat (5) tick();
    kern_clear[0] = 1'b1;
    tick();
    kern_clear[0] = 1'b0;
    chk("R11 clear", kern_alloc[0], 0);
    tick();
    chk("R11 stays clear with full queues", kern_alloc[0], 0);

    // R4 R8 short kernel: six blocks, lower cores first
    do_reset();
    kern_total[0] = 8'd0; kern_total[1] = 8'd6; sel_kernel = 2'd1; core_ready = '0;
    tick();
    chk("R4 alloc after 1", kern_alloc[1], 4);
    tick();
    chk("R4 alloc capped", kern_alloc[1], 6);
    tick();
    chk("R4 alloc stays", kern_alloc[1], 6);
    chk("R2 other kernel untouched", kern_alloc[0], 0);
    core_ready = 4'hF;
    tick(); disp_expect("R8 order c0", 1, 0, 1);
    tick(); disp_expect("R8 order c1", 1, 1, 1);
    tick(); disp_expect("R8 order c2", 1, 2, 1);
    tick(); disp_expect("R8 order c3", 1, 3, 1);
    tick(); disp_expect("R8 second c0", 1, 0, 1);
    tick(); disp_expect("R8 second c1", 1, 1, 1);
    tick(); disp_expect("R7 drained", 0, 0, 0);

    // R6 same-cycle fill and dispatch, R7 registered output
    do_reset();
    kern_total[1] = 8'd0; kern_total[0] = 8'd1; sel_kernel = 2'd0; core_ready = 4'hF;
    tick();
    disp_expect("R6 bypass dispatch", 1, 0, 0);
    chk("R4 single block", kern_alloc[0], 1);
    tick();
    disp_expect("R7 only once", 0, 0, 0);

    // R3 ownership mode
    concurrent_mode = 1'b0; core_ready = '0; core_busy = '0;
    kern_total[0] = 8'd0; kern_total[2] = 8'd2; kern_total[3] = 8'd8; sel_kernel = 2'd2;
    do_reset();
    tick();
    chk("R3 all cores own", core_kernel_valid, 15);
    chk("R3 core0 kernel", core_kernel[0], 2);
    chk("R3 core3 kernel", core_kernel[3], 2);
    chk("R3 alloc2", kern_alloc[2], 2);
    sel_kernel = 2'd3; core_busy = 4'b1000;
    tick();
    chk("R3 core2 switched", core_kernel[2], 3);
    chk("R3 busy core3 kept", core_kernel[3], 2);
    chk("R3 queued core0 kept", core_kernel[0], 2);
    chk("R3 alloc3", kern_alloc[3], 1);
    tick();
    chk("R3 core2 keeps filling", kern_alloc[3], 2);
    chk("R3 core1 kept", core_kernel[1], 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule